// File: doc/BRIEF.md
# Masked Event Interrupt Controller

This block gathers a small set of events into an 8-bit sticky pending register, gates it with an 8-bit enable mask and drives a single active-low interrupt line to a host. A free-running one-second tick, a reply from an attached peripheral bus, a periodic bus poll that returns data, and a generic per-bit event input all raise pending bits. The host talks to the block through a short command port: it loads the enable mask, turns periodic polling on with a 16-bit device-select mask or off again, and acknowledges events.

Acknowledge is selective. When a bus reply is waiting, the acknowledge returns a flag byte that holds only the reply-related bits and announces how many reply bytes follow. It then clears only those bits, so a tick or any other event stays pending for the next acknowledge. With no reply waiting, the acknowledge returns the whole pending byte and clears everything. The reply bytes themselves and the polled bus are outside this block; only their lengths and valid strobes cross its edge.

Pending bit positions are fixed: bit 4 is reply-ready, bit 3 is the one-second tick, and bit 2 marks a reply produced by automatic polling. Commands on `cmd_op` are encoded 0 = acknowledge, 1 = load enable mask, 2 = load poll select, 3 = stop polling.

Top module: `evt_irq_ctrl`

## Requirements
- R1: `irq_n` is 0 exactly when (pending AND mask) is nonzero, and it changes on the same clock edge as the pending register or the mask.
- R2: After synchronous reset the mask is 8'h18 (bits 4 and 3), all pending bits are 0, `irq_n` is 1, `rsp_valid` is 0, `poll_sel` is 0 and `poll_req` is 0.
- R3: The tick sets pending bit 3 on the edge `TICK_MS*CLK_PER_MS + 1` after reset release and again every `TICK_MS*CLK_PER_MS` edges, with no drift.
- R4: An acknowledge (op 0, argc 0) with bit 4 pending yields one `rsp_valid` pulse with `rsp_flags` = pending AND 8'h14 and `rsp_len` = stored reply length + 1. It clears only bits 4 and 2 and zeroes the stored length.
- R5: An acknowledge with bit 4 clear yields `rsp_flags` = the whole pending byte and `rsp_len` = 1, and clears every pending bit.
- R6: A load-mask command (op 1) with argc exactly 1 loads `cmd_arg[7:0]` as the mask. A load-mask command with any other argc, or an acknowledge with argc not 0, changes nothing and gives no response.
- R7: A load-poll-select command (op 2) with argc exactly 2 and a nonzero `cmd_arg` that differs from `poll_sel` restarts the poll period. `poll_req` then pulses for one cycle every `POLL_MS*CLK_PER_MS` edges after the command edge. Loading the same value again leaves the period running undisturbed.
- R8: Poll data (`pol_vld` with `pol_len` nonzero) sets bits 4 and 2 and stores `pol_len` only when bit 4 is not pending and no device reply arrives in the same cycle. Otherwise, and whenever `pol_len` is 0, it is ignored.
- R9: A stop-polling command (op 3) with argc 0, or a load-poll-select of zero, clears `poll_sel` and stops `poll_req`. Op 3 with a nonzero argc is ignored.
- R10: Pending bits are sticky. An event that sets a bit in the same cycle as an acknowledge clears it leaves the bit pending.
- R11: A device reply (`dev_rdy`) sets bit 4 only and stores `dev_len` as the reply length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 ack, 1 load mask, 2 load poll select, 3 stop polling |
| cmd_argc | input | ARGC_W | Number of argument bytes supplied with the command |
| cmd_arg | input | 16 | Argument: mask in [7:0], or poll select in [15:0] |
| evt_set | input | 8 | Generic per-bit event pulses into the pending register |
| dev_rdy | input | 1 | Device reply ready |
| dev_len | input | LEN_W | Length of the device reply |
| pol_vld | input | 1 | Poll result strobe |
| pol_len | input | LEN_W | Length of the poll result, 0 = no data |
| irq_n | output | 1 | Active-low interrupt |
| rsp_valid | output | 1 | Acknowledge response valid, one cycle |
| rsp_flags | output | 8 | Flag byte of the response |
| rsp_len | output | LEN_W+1 | Total response bytes: flag byte plus reply bytes |
| poll_req | output | 1 | One-cycle request to poll the bus |
| poll_sel | output | 16 | Active poll device-select mask |

## Verification
Every output is a register, so a command, event or poll result driven before edge n shows up on `irq_n`, `rsp_*` and the pending state just after edge n. The bench drives on the falling edge and samples 1 ns after the next rising edge, stepping a reference model by exactly one edge per step. The tick takes one more edge than its counter period, because the timer strobe is registered before it reaches the pending register. The first tick is therefore expected at edge P+1 after reset release, and `poll_req` exactly Q edges after the edge that accepted the poll-select command. The model counts edges from reset release and from each poll restart, and compares at every step against those exact positions.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int EVT_W = 8;
  localparam int SEL_W = 16;

  // pending bit positions decoded by host software
  localparam int B_AUTO  = 2;
  localparam int B_TICK  = 3;
  localparam int B_REPLY = 4;

  localparam logic [EVT_W-1:0] REPLY_FLAGS = EVT_W'((1 << B_REPLY) | (1 << B_AUTO));
  localparam logic [EVT_W-1:0] RST_MASK    = EVT_W'((1 << B_REPLY) | (1 << B_TICK));

  typedef enum logic [1:0] {
    OP_ACK      = 2'd0,
    OP_MASK     = 2'd1,
    OP_POLL_SET = 2'd2,
    OP_POLL_OFF = 2'd3
  } evt_op_e;
endpackage

// File: rtl/evt_period_timer.sv
module evt_period_timer #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic restart,
  output logic fire
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else if (en) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        fire <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        fire <= 1'b0;
      end
    end else begin
      fire <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_poll_ctrl.sv
module evt_poll_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned POLL_CYC = 30000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_go,
  input  logic             off_go,
  input  logic [SEL_W-1:0] sel_val,
  output logic [SEL_W-1:0] poll_sel,
  output logic             poll_req
);
  logic [SEL_W-1:0] sel_nx;
  logic             restart;

  always_comb begin
    sel_nx = poll_sel;
    if (sel_go)      sel_nx = sel_val;
    else if (off_go) sel_nx = '0;
    restart = (sel_go || off_go) && (sel_nx != poll_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) poll_sel <= '0;
    else     poll_sel <= sel_nx;
  end

  evt_period_timer #(.PERIOD(POLL_CYC)) u_poll_tmr (
    .clk     (clk),
    .rst     (rst),
    .en      (poll_sel != '0),
    .restart (restart),
    .fire    (poll_req)
  );
endmodule

// File: rtl/evt_pending_core.sv
module evt_pending_core
  import evt_irq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_go,
  input  logic             mask_go,
  input  logic [EVT_W-1:0] mask_val,
  input  logic [EVT_W-1:0] evt_set,
  input  logic             tick,
  input  logic             dev_rdy,
  input  logic [LEN_W-1:0] dev_len,
  input  logic             pol_vld,
  input  logic [LEN_W-1:0] pol_len,
  output logic [EVT_W-1:0] pend,
  output logic [EVT_W-1:0] mask,
  output logic             irq_n,
  output logic             rsp_valid,
  output logic [EVT_W-1:0] rsp_flags,
  output logic [LEN_W:0]   rsp_len
);
  logic [LEN_W-1:0] rlen, rlen_nx;
  logic [EVT_W-1:0] clr, setv, pend_nx, mask_nx;
  logic             reply_pend, poll_hit;

  assign reply_pend = pend[B_REPLY];
  assign poll_hit   = pol_vld && (pol_len != '0) && !reply_pend && !dev_rdy;

  always_comb begin
    clr = '0;
    if (ack_go) clr = reply_pend ? REPLY_FLAGS : '1;
    setv = evt_set;
    if (tick)     setv[B_TICK]  = 1'b1;
    if (dev_rdy)  setv[B_REPLY] = 1'b1;
    if (poll_hit) setv = setv | REPLY_FLAGS;
    mask_nx = mask_go ? mask_val : mask;
    rlen_nx = rlen;
    if (ack_go && reply_pend) rlen_nx = '0;
    if (dev_rdy)       rlen_nx = dev_len;
    else if (poll_hit) rlen_nx = pol_len;
  end

  // sticky cells: a new event outranks a clear in the same cycle
  for (genvar i = 0; i < EVT_W; i++) begin : g_cell
    assign pend_nx[i] = (pend[i] && !clr[i]) || setv[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      mask      <= RST_MASK;
      rlen      <= '0;
      irq_n     <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_flags <= '0;
      rsp_len   <= '0;
    end else begin
      pend      <= pend_nx;
      mask      <= mask_nx;
      rlen      <= rlen_nx;
      irq_n     <= ~|(pend_nx & mask_nx);
      rsp_valid <= ack_go;
      if (ack_go) begin
        rsp_flags <= reply_pend ? (pend & REPLY_FLAGS) : pend;
        rsp_len   <= reply_pend ? ({1'b0, rlen} + 1'b1) : (LEN_W+1)'(1);
      end
    end
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int CLK_PER_MS = 250000,
  parameter int TICK_MS    = 1000,
  parameter int POLL_MS    = 30,
  parameter int LEN_W      = 8,
  parameter int ARGC_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ARGC_W-1:0] cmd_argc,
  input  logic [15:0]       cmd_arg,
  input  logic [7:0]        evt_set,
  input  logic              dev_rdy,
  input  logic [LEN_W-1:0]  dev_len,
  input  logic              pol_vld,
  input  logic [LEN_W-1:0]  pol_len,
  output logic              irq_n,
  output logic              rsp_valid,
  output logic [7:0]        rsp_flags,
  output logic [LEN_W:0]    rsp_len,
  output logic              poll_req,
  output logic [15:0]       poll_sel
);
  localparam int unsigned TICK_CYC = CLK_PER_MS * TICK_MS;
  localparam int unsigned POLL_CYC = CLK_PER_MS * POLL_MS;

  evt_op_e          op;
  logic             ack_go, mask_go, sel_go, off_go, tick;
  logic [EVT_W-1:0] pend, mask;

  assign op      = evt_op_e'(cmd_op);
  assign ack_go  = cmd_valid && (op == OP_ACK)      && (cmd_argc == ARGC_W'(0));
  assign mask_go = cmd_valid && (op == OP_MASK)     && (cmd_argc == ARGC_W'(1));
  assign sel_go  = cmd_valid && (op == OP_POLL_SET) && (cmd_argc == ARGC_W'(2));
  assign off_go  = cmd_valid && (op == OP_POLL_OFF) && (cmd_argc == ARGC_W'(0));

  evt_period_timer #(.PERIOD(TICK_CYC)) u_tick_tmr (
    .clk     (clk),
    .rst     (rst),
    .en      (1'b1),
    .restart (1'b0),
    .fire    (tick)
  );

  evt_poll_ctrl #(.POLL_CYC(POLL_CYC)) u_poll (
    .clk      (clk),
    .rst      (rst),
    .sel_go   (sel_go),
    .off_go   (off_go),
    .sel_val  (cmd_arg),
    .poll_sel (poll_sel),
    .poll_req (poll_req)
  );

  evt_pending_core #(.LEN_W(LEN_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .ack_go    (ack_go),
    .mask_go   (mask_go),
    .mask_val  (cmd_arg[7:0]),
    .evt_set   (evt_set),
    .tick      (tick),
    .dev_rdy   (dev_rdy),
    .dev_len   (dev_len),
    .pol_vld   (pol_vld),
    .pol_len   (pol_len),
    .pend      (pend),
    .mask      (mask),
    .irq_n     (irq_n),
    .rsp_valid (rsp_valid),
    .rsp_flags (rsp_flags),
    .rsp_len   (rsp_len)
  );
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
  parameter int LEN_W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           irq_n,
  input logic [7:0]     pend,
  input logic [7:0]     mask,
  input logic [7:0]     evt_set,
  input logic           rsp_valid,
  input logic [7:0]     rsp_flags,
  input logic [LEN_W:0] rsp_len,
  input logic           poll_req,
  input logic [15:0]    poll_sel
);
  a_r1_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_n == ~|(pend & mask));

  a_r2_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask == 8'h18 && pend == 8'h00 && irq_n && !rsp_valid));

  a_r4_reply_flags_only: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_flags[4]) |-> ((rsp_flags & 8'hEB) == 8'h00));

  a_r5_plain_len_one: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_flags[4]) |-> (rsp_len == (LEN_W+1)'(1)));

  a_r7_poll_needs_sel: assert property (@(posedge clk) disable iff (rst)
    poll_req |-> (poll_sel != 16'h0000));

  a_r10_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((pend & $past(evt_set)) == $past(evt_set)));
endmodule

bind evt_irq_ctrl evt_irq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_n     (irq_n),
  .pend      (pend),
  .mask      (mask),
  .evt_set   (evt_set),
  .rsp_valid (rsp_valid),
  .rsp_flags (rsp_flags),
  .rsp_len   (rsp_len),
  .poll_req  (poll_req),
  .poll_sel  (poll_sel)
);

// File: tb/sim_evt_irq_ctrl.sv
`timescale 1ns/1ps
module sim_evt_irq_ctrl;
  localparam int CPM = 4;
  localparam int P   = CPM * 1000;
  localparam int Q   = CPM * 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 0;
  logic [1:0]  cmd_op = 0;
  logic [2:0]  cmd_argc = 0;
  logic [15:0] cmd_arg = 0;
  logic [7:0]  evt_set = 0;
  logic        dev_rdy = 0;
  logic [7:0]  dev_len = 0;
  logic        pol_vld = 0;
  logic [7:0]  pol_len = 0;
  logic        irq_n, rsp_valid, poll_req;
  logic [7:0]  rsp_flags;
  logic [8:0]  rsp_len;
  logic [15:0] poll_sel;

  int total = 0, bad = 0, n = 0;
  bit done = 0;
  logic [7:0]  m_pend = 8'h00, m_mask = 8'h18, m_rlen = 8'h00;
  logic [15:0] m_sel = 16'h0000;
  int          m_s = 0;

  always #2 clk = ~clk;

  evt_irq_ctrl #(.CLK_PER_MS(CPM)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_argc(cmd_argc), .cmd_arg(cmd_arg), .evt_set(evt_set),
    .dev_rdy(dev_rdy), .dev_len(dev_len), .pol_vld(pol_vld),
    .pol_len(pol_len), .irq_n(irq_n), .rsp_valid(rsp_valid),
    .rsp_flags(rsp_flags), .rsp_len(rsp_len), .poll_req(poll_req),
    .poll_sel(poll_sel)
  );

  task automatic chk(input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [7:0] ack_flags(input logic [7:0] p);
    return p[4] ? (p & 8'h14) : p;
  endfunction

  // one clock edge: predict, advance, compare
  task automatic step(input string tag);
    logic [7:0] clr, setv;
    logic       e_rv, hit, e_poll;
    logic [7:0] e_fl;
    logic [8:0] e_len;
    logic [15:0] sel_nx;
    n++;
    clr = 0; e_rv = 0; e_fl = 0; e_len = 0; sel_nx = m_sel;
    hit = pol_vld && pol_len != 0 && !m_pend[4] && !dev_rdy;
    if (cmd_valid) begin
      case (cmd_op)
        2'd0: if (cmd_argc == 0) begin
          e_rv = 1; e_fl = ack_flags(m_pend);
          e_len = m_pend[4] ? {1'b0, m_rlen} + 9'd1 : 9'd1;
          clr = m_pend[4] ? 8'h14 : 8'hFF;
        end
        2'd1: if (cmd_argc == 1) m_mask = cmd_arg[7:0];
        2'd2: if (cmd_argc == 2) sel_nx = cmd_arg;
        default: if (cmd_argc == 0) sel_nx = 16'h0;
      endcase
    end
    if (sel_nx != m_sel) begin m_s = n; m_sel = sel_nx; end
    setv = evt_set;
    if (n > 1 && (n - 1) % P == 0) setv[3] = 1;
    if (dev_rdy) setv[4] = 1;
    if (hit) setv = setv | 8'h14;
    if (cmd_valid && cmd_op == 0 && cmd_argc == 0 && m_pend[4]) m_rlen = 0;
    if (dev_rdy) m_rlen = dev_len;
    else if (hit) m_rlen = pol_len;
    m_pend = (m_pend & ~clr) | setv;
    e_poll = (m_sel != 0) && (n > m_s) && ((n - m_s) % Q == 0);
    @(posedge clk); #1;
    chk(tag, "irq_n", 16'(irq_n), 16'(~|(m_pend & m_mask)));
    chk(tag, "rsp_valid", 16'(rsp_valid), 16'(e_rv));
    if (e_rv) begin
      chk(tag, "rsp_flags", 16'(rsp_flags), 16'(e_fl));
      chk(tag, "rsp_len", 16'(rsp_len), 16'(e_len));
    end
    chk(tag, "poll_req", 16'(poll_req), 16'(e_poll));
    chk(tag, "poll_sel", poll_sel, m_sel);
    @(negedge clk);
    cmd_valid = 0; evt_set = 0; dev_rdy = 0; pol_vld = 0;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [2:0] argc,
                     input logic [15:0] arg, input string tag);
    cmd_valid = 1; cmd_op = op; cmd_argc = argc; cmd_arg = arg;
    step(tag);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired at step %0d", n);
    finish_up();
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    // R2: idle state after reset
    step("R2");
    evt_set = 8'h01; step("R2");             // bit 0 masked at reset
    cmd(2'd0, 3'd0, 16'h0, "R5");            // returns 0x01, len 1
    // R6: malformed commands ignored
    cmd(2'd1, 3'd2, 16'h00FF, "R6");
    evt_set = 8'h01; step("R6");
    cmd(2'd0, 3'd1, 16'h0, "R6");
    cmd(2'd1, 3'd1, 16'h0001, "R6");          // irq now low
    cmd(2'd0, 3'd0, 16'h0, "R5");
    cmd(2'd1, 3'd1, 16'h0018, "R6");
    // R11 / R4: selective acknowledge
    dev_rdy = 1; dev_len = 8'd3; step("R11");
    evt_set = 8'h40; step("R4");
    cmd(2'd0, 3'd0, 16'h0, "R4");             // 0x10, len 4
    cmd(2'd0, 3'd0, 16'h0, "R5");             // 0x40 left pending
    // R10: set and clear in one cycle
    dev_rdy = 1; dev_len = 8'd2; step("R10");
    dev_rdy = 1; dev_len = 8'd6; cmd(2'd0, 3'd0, 16'h0, "R10");
    cmd(2'd0, 3'd0, 16'h0, "R10");            // len 7
    evt_set = 8'h20; cmd(2'd0, 3'd0, 16'h0, "R10");
    cmd(2'd0, 3'd0, 16'h0, "R10");            // 0x20 survived
    // R7 / R8: polling
    cmd(2'd2, 3'd2, 16'hFFFF, "R7");
    for (int i = 0; i < Q / 2; i++) step("R7");
    cmd(2'd2, 3'd2, 16'hFFFF, "R7");          // same select: no restart
    for (int i = 0; i < Q + 4; i++) step("R7");
    pol_vld = 1; pol_len = 8'd2; step("R8");
    pol_vld = 1; pol_len = 8'd5; step("R8");  // reply already pending
    cmd(2'd0, 3'd0, 16'h0, "R8");             // 0x14, len 3
    pol_vld = 1; pol_len = 8'd0; step("R8");
    cmd(2'd0, 3'd0, 16'h0, "R8");
    // R9: stopping the poll
    cmd(2'd3, 3'd1, 16'h0, "R9");
    for (int i = 0; i < 10; i++) step("R9");
    cmd(2'd3, 3'd0, 16'h0, "R9");
    for (int i = 0; i < Q + 5; i++) step("R9");
    cmd(2'd2, 3'd2, 16'h0001, "R7");
    cmd(2'd2, 3'd2, 16'h0000, "R9");
    for (int i = 0; i < Q + 5; i++) step("R9");
    // R3: tick positions
    while (n < 2 * P + 4) step("R3");
    // random mix
    for (int i = 0; i < 24000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 25) begin
        cmd_valid = 1; cmd_op = 2'($urandom_range(0, 3));
        cmd_argc = ($urandom_range(0, 9) < 7) ?
                   (cmd_op == 2'd1 ? 3'd1 : cmd_op == 2'd2 ? 3'd2 : 3'd0) :
                   3'($urandom_range(0, 3));
        case ($urandom_range(0, 3))
          0: cmd_arg = 16'h0000;
          1: cmd_arg = 16'($urandom);
          2: cmd_arg = poll_sel;
          default: cmd_arg = 16'h0018;
        endcase
      end
      if ($urandom_range(0, 99) < 4) evt_set = 8'(1 << $urandom_range(0, 7));
      if ($urandom_range(0, 99) < 5) begin dev_rdy = 1; dev_len = 8'($urandom_range(1, 9)); end
      if ($urandom_range(0, 99) < 8) begin pol_vld = 1; pol_len = 8'($urandom_range(0, 5)); end
      step("R1_R4_R5_R7");
    end
    finish_up();
  end
endmodule